// File: doc/BRIEF.md
# Oversampled Serial Receiver with Idle Timeout

This block is the receive half of a fixed-format asynchronous serial port: 8 data bits, no parity, one stop bit. A programmable divider produces an oversampling tick. Fourteen ticks make one bit time. A small state machine finds the start bit and confirms it at mid-bit. It then samples each data bit at the centre of its window, least significant bit first, and checks the stop bit. Every received character is written to a receive FIFO as an 11-bit entry. The entry holds the data byte, a framing-error flag and a break flag.

Alongside the receiver runs an inactivity timer. Whenever the FIFO holds data and no new character arrives and no character is read out, the timer counts whole character times. A character time is 140 ticks. After a selectable number of character times it raises one timeout strobe, so that software can drain a FIFO that never reached its trigger level. The FIFO itself lives outside the block: the block writes to it and watches its fill level.

Top module: `hsrx_top`

## Requirements
- R1: Each frame is one low start bit, then 8 data bits least significant bit first, then one stop bit. Every bit lasts 14 ticks. A data bit is sampled at the 7th tick of its window, counting from the tick on which the start edge was seen.
- R2: One tick occurs every `rate_i`+1 clocks, so the bit rate is clk / ((`rate_i`+1)·14). This also holds for `rate_i` = 0, which gives one tick per clock.
- R3: Each character produces exactly one one-cycle `wr_en_o` pulse. The entry `wr_data_o` holds the data byte in bits 7:0, a 0 in bit 8, the framing-error flag in bit 9 and the break flag in bit 10.
- R4: A character whose stop bit samples low, with nonzero data, is stored with bit 9 set and bit 10 clear.
- R5: If the line is low for a whole frame (start, all data bits and stop), the block stores an entry with data 0x00 and both bit 9 and bit 10 set. It also pulses `brk_o` in the same cycle as that write.
- R6: After any missing stop bit, no new character is accepted until the line has been sampled high. A line that stays low after a break produces no further entries.
- R7: A low pulse that has ended before the mid-bit confirmation of the start bit is discarded and writes nothing.
- R8: `tmo_sel_i` = 0 disables the timeout. Values 1, 2 and 3 select 4, 8 and 16 character times (140 ticks each) of inactivity, after which `tmo_o` pulses for one cycle.
- R9: The timer runs only while `rx_level_i` is nonzero. It restarts on every write and on every drop of `rx_level_i`, and it fires at most once per inactivity period.
- R10: During and directly after reset, `wr_en_o`, `brk_o` and `tmo_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| rate_i | input | 8 | Divider value; one tick every rate_i+1 clocks |
| tmo_sel_i | input | 2 | Timeout select: 0 off, 1/2/3 = 4/8/16 character times |
| rx_level_i | input | LVL_W (7) | Current fill level of the receive FIFO |
| wr_en_o | output | 1 | FIFO write strobe, one cycle per character |
| wr_data_o | output | 11 | FIFO entry {break, frame error, 0, data[7:0]} |
| brk_o | output | 1 | Break event strobe |
| tmo_o | output | 1 | Receive timeout event strobe |

## Verification
The hardest states to reach are the ones that follow a fault on the line. The first is the hold after a break, where the line stays low far past the frame. The bench keeps the line low for twenty extra bit times and confirms that no phantom characters appear. The second is a timeout that is re-armed by a FIFO read. The bench drives the FIFO level input directly: it lowers the level by one without a new character, then measures the second timeout from the moment of the read. It also drops the level to zero and checks that the timer stays silent.

// File: rtl/hsrx_pkg.sv
package hsrx_pkg;
  localparam int OVS        = 14;          // ticks per bit
  localparam int MID_TICK   = 7;           // confirmation / sample point
  localparam int DATA_BITS  = 8;
  localparam int BITS_CHAR  = DATA_BITS + 2;
  localparam int CHAR_TICKS = OVS * BITS_CHAR;
  localparam int ENTRY_W    = DATA_BITS + 3;
  localparam int BIT_EMPTY  = DATA_BITS;
  localparam int BIT_FERR   = DATA_BITS + 1;
  localparam int BIT_BRK    = DATA_BITS + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD
  } rx_state_t;
endpackage

// File: rtl/hsrx_tick.sv
module hsrx_tick #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= rate_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hsrx_frame.sv
module hsrx_frame
  import hsrx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_i,
  input  logic               line_i,
  output logic               wr_en_o,
  output logic [ENTRY_W-1:0] wr_data_o,
  output logic               brk_o
);
  localparam int TC_W  = $clog2(OVS);
  localparam int BIX_W = $clog2(DATA_BITS);

  rx_state_t              st_q;
  logic [TC_W-1:0]        tcnt_q;
  logic [BIX_W-1:0]       bidx_q;
  logic [DATA_BITS-1:0]   shift_q;
  logic                   bit_end;
  logic                   mid_hit;
  logic                   is_break;

  assign bit_end  = (tcnt_q == TC_W'(OVS - 1));
  assign mid_hit  = (tcnt_q == TC_W'(MID_TICK - 1));
  assign is_break = !line_i && (shift_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      tcnt_q    <= '0;
      bidx_q    <= '0;
      shift_q   <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      brk_o     <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      brk_o   <= 1'b0;
      if (tick_i) begin
        case (st_q)
          ST_IDLE: begin
            if (!line_i) begin
              st_q   <= ST_START;
              tcnt_q <= '0;
            end
          end
          ST_START: begin
            if (mid_hit) begin
              tcnt_q <= '0;
              bidx_q <= '0;
              st_q   <= line_i ? ST_IDLE : ST_DATA;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              tcnt_q  <= '0;
              shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
              if (bidx_q == BIX_W'(DATA_BITS - 1)) st_q <= ST_STOP;
              else                                  bidx_q <= bidx_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_end) begin
              tcnt_q    <= '0;
              wr_en_o   <= 1'b1;
              brk_o     <= is_break;
              wr_data_o <= {is_break, !line_i, 1'b0, shift_q};
              st_q      <= line_i ? ST_IDLE : ST_HOLD;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          ST_HOLD: begin
            if (line_i) st_q <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hsrx_idle.sv
module hsrx_idle
  import hsrx_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [1:0]       sel_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             tmo_o
);
  localparam int TT_W = $clog2(CHAR_TICKS);
  localparam int CC_W = 5;

  logic [LVL_W-1:0] lvl_q;
  logic [TT_W-1:0]  tt_q;
  logic [CC_W-1:0]  cc_q;
  logic [CC_W-1:0]  lim_m1;
  logic             armed_q;
  logic             restart;

  always_comb begin
    case (sel_i)
      2'd1:    lim_m1 = CC_W'(3);
      2'd2:    lim_m1 = CC_W'(7);
      default: lim_m1 = CC_W'(15);
    endcase
  end

  assign restart = wr_i || (level_i < lvl_q) || (level_i == '0) || (sel_i == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      tt_q    <= '0;
      cc_q    <= '0;
      armed_q <= 1'b1;
      tmo_o   <= 1'b0;
    end else begin
      lvl_q <= level_i;
      tmo_o <= 1'b0;
      if (restart) begin
        tt_q    <= '0;
        cc_q    <= '0;
        armed_q <= 1'b1;
      end else if (tick_i && armed_q) begin
        if (tt_q == TT_W'(CHAR_TICKS - 1)) begin
          tt_q <= '0;
          if (cc_q == lim_m1) begin
            cc_q    <= '0;
            armed_q <= 1'b0;
            tmo_o   <= 1'b1;
          end else begin
            cc_q <= cc_q + 1'b1;
          end
        end else begin
          tt_q <= tt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hsrx_top.sv
module hsrx_top
  import hsrx_pkg::*;
#(
  parameter int RATE_W = 8,
  parameter int LVL_W  = 7,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [1:0]        tmo_sel_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              wr_en_o,
  output logic [10:0]       wr_data_o,
  output logic              brk_o,
  output logic              tmo_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              tick;
  logic              wr_en;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_N-2:0], rxd_i};
  end

  hsrx_tick #(.RATE_W(RATE_W)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .rate_i (rate_i),
    .tick_o (tick)
  );

  hsrx_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .line_i    (sync_q[SYNC_N-1]),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data_o),
    .brk_o     (brk_o)
  );

  hsrx_idle #(.LVL_W(LVL_W)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .wr_i    (wr_en),
    .sel_i   (tmo_sel_i),
    .level_i (rx_level_i),
    .tmo_o   (tmo_o)
  );

  assign wr_en_o = wr_en;
endmodule

// File: rtl/hsrx_checks.sv
module hsrx_checks #(
  parameter int LVL_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en_o,
  input logic [10:0]      wr_data_o,
  input logic             brk_o,
  input logic             tmo_o,
  input logic [1:0]       tmo_sel_i,
  input logic [LVL_W-1:0] rx_level_i
);
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst) wr_en_o |=> !wr_en_o); // R3
  AST_EMPTY_BIT_ZERO: assert property (@(posedge clk) disable iff (rst) wr_en_o |-> !wr_data_o[8]); // R3
  AST_BRK_WITH_WRITE: assert property (@(posedge clk) disable iff (rst) brk_o |-> (wr_en_o && wr_data_o[10])); // R5
  AST_BRK_ENTRY_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_data_o[10]) |-> (wr_data_o[9] && (wr_data_o[7:0] == 8'h00))); // R5
  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst) tmo_o |=> !tmo_o); // R9
  AST_TMO_OFF: assert property (@(posedge clk) disable iff (rst) (tmo_sel_i == 2'd0) |=> !tmo_o); // R8
  AST_TMO_EMPTY: assert property (@(posedge clk) disable iff (rst) (rx_level_i == '0) |=> !tmo_o); // R9
endmodule

bind hsrx_top hsrx_checks #(.LVL_W(LVL_W)) u_hsrx_checks (
  .clk        (clk),
  .rst        (rst),
  .wr_en_o    (wr_en_o),
  .wr_data_o  (wr_data_o),
  .brk_o      (brk_o),
  .tmo_o      (tmo_o),
  .tmo_sel_i  (tmo_sel_i),
  .rx_level_i (rx_level_i)
);

// File: tb/hsrx_top_bench.sv
module hsrx_top_bench;
  localparam int LVL_W = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rxd = 1'b1;
  logic [7:0]       rate = 8'd1;
  logic [1:0]       tsel = 2'd0;
  int               level = 0;
  logic [LVL_W-1:0] lvl;
  logic             wr_en;
  logic [10:0]      wr_data;
  logic             brk;
  logic             tmo;

  int checks = 0, errors = 0, cyc = 0;
  int wr_cnt = 0, tmo_cnt = 0, last_wr = 0, last_tmo = 0;
  logic [10:0] expq[$];
  logic [10:0] exp_e;

  assign lvl = level[LVL_W-1:0];
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hsrx_top u_hsrx_top (
    .clk(clk), .rst(rst), .rxd_i(rxd), .rate_i(rate), .tmo_sel_i(tsel),
    .rx_level_i(lvl), .wr_en_o(wr_en), .wr_data_o(wr_data), .brk_o(brk), .tmo_o(tmo)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (brk && !wr_en) chk("R5 break strobe without write", 1'b0, 1, 0);
      if (wr_en) begin
        wr_cnt++;
        last_wr = cyc;
        level++;
        if (expq.size() == 0) begin
          chk("R3 unexpected write", 1'b0, int'(wr_data), 0);
        end else begin
          exp_e = expq.pop_front();
          chk("R1 R3 entry", wr_data == exp_e, int'(wr_data), int'(exp_e));
          chk("R5 break strobe", brk == exp_e[10], int'(brk), int'(exp_e[10]));
        end
      end
      if (tmo) begin
        tmo_cnt++;
        last_tmo = cyc;
      end
    end
  end

  task automatic send(input logic [7:0] d, input logic stop_hi);
    int bt;
    bt = 14 * (int'(rate) + 1);
    rxd = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (bt) @(negedge clk);
    end
    rxd = stop_hi;
    repeat (bt) @(negedge clk);
    rxd = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic sendx(input logic [7:0] d);
    expq.push_back({3'b000, d});
    send(d, 1'b1);
  endtask

  task automatic tmo_window(input string req, input int chars, input int t0, input int n0);
    int ex, slack;
    ex = chars * 140 * (int'(rate) + 1);
    slack = 3 * (int'(rate) + 1) + 6;
    chk(req, tmo_cnt == n0 + 1, tmo_cnt, n0 + 1);
    chk(req, (last_tmo - t0 >= ex - slack) && (last_tmo - t0 <= ex + slack), last_tmo - t0, ex);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0, c0, bt;
    repeat (3) @(negedge clk);
    chk("R10 outputs in reset", {wr_en, brk, tmo} == 3'b000, int'({wr_en, brk, tmo}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 outputs after reset", {wr_en, brk, tmo} == 3'b000, int'({wr_en, brk, tmo}), 0);
    repeat (40) @(negedge clk);

    // R1 R3: assorted bytes
    sendx(8'hA5); sendx(8'h3C); sendx(8'hFF); sendx(8'h01);
    chk("R1 four characters written", wr_cnt == 4, wr_cnt, 4);

    // R2: one tick per clock
    rate = 8'd0;
    repeat (20) @(negedge clk);
    sendx(8'h5A);
    rate = 8'd2;
    repeat (60) @(negedge clk);
    sendx(8'hC3);
    rate = 8'd1;
    repeat (60) @(negedge clk);
    chk("R2 characters at other rates", wr_cnt == 6, wr_cnt, 6);

    // R4: framing error
    expq.push_back({3'b010, 8'h81});
    send(8'h81, 1'b0);
    sendx(8'h7E);

    // R5 R6: break, then line held low
    bt = 28;
    expq.push_back({3'b110, 8'h00});
    n0 = wr_cnt;
    rxd = 1'b0;
    repeat (bt * 30) @(negedge clk);
    chk("R6 single entry while line low", wr_cnt == n0 + 1, wr_cnt, n0 + 1);
    rxd = 1'b1;
    repeat (bt * 2) @(negedge clk);
    sendx(8'h42);

    // R7: short glitch
    n0 = wr_cnt;
    rxd = 1'b0;
    repeat (4 * 2) @(negedge clk);
    rxd = 1'b1;
    repeat (bt * 12) @(negedge clk);
    chk("R7 glitch ignored", wr_cnt == n0, wr_cnt, n0);
    sendx(8'h99);

    // R8 R9: timeout
    level = 0;
    tsel = 2'd1;
    sendx(8'h11); sendx(8'h22);
    n0 = tmo_cnt;
    repeat (4 * 140 * 2 + 200) @(negedge clk);
    tmo_window("R8 timeout 4 chars", 4, last_wr, n0);
    repeat (3000) @(negedge clk);
    chk("R9 single timeout per idle", tmo_cnt == n0 + 1, tmo_cnt, n0 + 1);
    n0 = tmo_cnt;
    level = level - 1;
    c0 = cyc;
    repeat (4 * 140 * 2 + 200) @(negedge clk);
    tmo_window("R9 read restarts timer", 4, c0, n0);
    n0 = tmo_cnt;
    level = 0;
    repeat (3000) @(negedge clk);
    chk("R9 no timeout with empty FIFO", tmo_cnt == n0, tmo_cnt, n0);
    tsel = 2'd0;
    sendx(8'h33);
    repeat (3000) @(negedge clk);
    chk("R8 timeout disabled", tmo_cnt == n0, tmo_cnt, n0);
    tsel = 2'd2;
    sendx(8'h44);
    repeat (8 * 140 * 2 + 200) @(negedge clk);
    tmo_window("R8 timeout 8 chars", 8, last_wr, n0);

    chk("R3 all expected entries seen", expq.size() == 0, expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule